// File: doc/BRIEF.md
# Configuration change protection unit

This block stands between software and a small set of sensitive controls. Software first writes a key value to the block's single register. That key opens a short window, measured in retired instructions. While the window is open, the neighbouring logic may accept one write to a protected configuration register, or one write to the flash high byte that launches self-programming. The two keys are independent. Each one has its own window and its own status bit in the read-back value.

While either window is open, the block asks the interrupt controller to hold off all interrupts, so that the short unlock sequence cannot be split by a handler. When the window closes, the hold is released and pending interrupts are taken again in their usual priority order.

A window ends in one of three ways: it runs out after four retired instructions, the guarded write it allowed uses it up, or software writes a value that is not a key. A guarded write attempted with no window open is blocked, and the block reports it with a one-cycle violation pulse.

Top module: `ccp_unit`

## Requirements
- R1: After reset, rd_data is 0x00 and prot_allow, spm_armed, irq_hold, prog_start and violation are all low.
- R2: A register write of 0xD8 raises prot_allow and rd_data bit 0 from the next cycle. Both stay high until four retire strobes have been seen after the write cycle. Cycles without a retire strobe do not count, and a retire strobe in the write cycle itself does not count.
- R3: A register write of 0xE7 raises spm_armed and rd_data bit 1 from the next cycle. Both stay high for four retire strobes, counted the same way as in R2, and then clear by themselves.
- R4: rd_data bits 7 to 2 always read as zero.
- R5: irq_hold is high exactly when at least one of the two windows is open.
- R6: A register write of any value other than 0xD8 or 0xE7 closes both windows from the next cycle.
- R7: A prot_wr strobe while the protected-register window is open sees prot_allow high in that cycle, and the window is closed from the next cycle.
- R8: A flash_hi_wr strobe while the self-programming window is open gives a prog_start pulse in that same cycle, and the window is closed from the next cycle.
- R9: A prot_wr strobe while its window is closed, or a flash_hi_wr strobe while its window is closed, gives no allow and no prog_start. It raises violation for exactly the following cycle.
- R10: Writing a valid key while a window is open reloads the count of the function that key selects. The count of the other window continues unchanged.
- R11: When a register write coincides with a consuming strobe or a retire strobe in the same cycle, the register write decides the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the key register |
| wr_data | input | 8 | Value written to the key register |
| rd_data | output | 8 | Read-back value: bit 0 is the protected window, bit 1 is the self-programming window |
| retire | input | 1 | One instruction retired in this cycle |
| prot_wr | input | 1 | A protected configuration register is being written |
| flash_hi_wr | input | 1 | The flash high byte is being written |
| prot_allow | output | 1 | A protected register write is permitted |
| spm_armed | output | 1 | Self-programming is armed |
| prog_start | output | 1 | Start self-programming (one-cycle pulse) |
| irq_hold | output | 1 | Hold off interrupts |
| violation | output | 1 | A guarded write was attempted with no window open (one-cycle pulse) |

## Verification
A reference model is compared with the block on every cycle across several input patterns, and each pattern separates a different set of faulty designs.

- **Sparse retire strobes** inside a window show whether the block counts retired instructions or plain clock cycles.
- **Closing paths:** a window that runs out, one that a guarded write uses up, and one that a bad key closes each exercise a different way for a window to end.
- **Overlapping windows** with a mid-window reload show whether a reload wrongly restarts or closes the other function's window.
- **Coincident strobes** show whether the same-cycle priority is correct and whether the violation pulse depends on the right window.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

   // Class of the value seen on the key register write port
   typedef enum logic [1:0] {
      KC_NONE = 2'd0,
      KC_PROT = 2'd1,
      KC_SPM  = 2'd2,
      KC_BAD  = 2'd3
   } key_class_e;

   // Window index used in the per-function arrays
   localparam int FN_PROT = 0;
   localparam int FN_SPM  = 1;
   localparam int FN_NUM  = 2;

endpackage

// File: rtl/ccp_key_decode.sv
module ccp_key_decode
   import ccp_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] KEY_PROT = 8'hD8,
   parameter logic [DATA_W-1:0] KEY_SPM  = 8'hE7
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output key_class_e        kclass
);

   always_comb begin
      if (!wr_en)
         kclass = KC_NONE;
      else if (wr_data == KEY_PROT)
         kclass = KC_PROT;
      else if (wr_data == KEY_SPM)
         kclass = KC_SPM;
      else
         kclass = KC_BAD;
   end

endmodule

// File: rtl/ccp_window.sv
module ccp_window #(
   parameter int WIN_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic load,
   input  logic consume,
   input  logic tick,
   output logic active
);

   localparam int CNT_W = $clog2(WIN_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIN_LEN);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   assign active = (cnt_q != '0);

   // Order of precedence: bad key, own key, consuming write, retire
   always_comb begin
      cnt_d = cnt_q;
      if (kill)
         cnt_d = '0;
      else if (load)
         cnt_d = CNT_FULL;
      else if (consume)
         cnt_d = '0;
      else if (tick && active)
         cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
   import ccp_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                WIN_LEN  = 4,
   parameter logic [DATA_W-1:0] KEY_PROT = 8'hD8,
   parameter logic [DATA_W-1:0] KEY_SPM  = 8'hE7,
   parameter bit                REG_VIOL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              retire,
   input  logic              prot_wr,
   input  logic              flash_hi_wr,
   output logic              prot_allow,
   output logic              spm_armed,
   output logic              prog_start,
   output logic              irq_hold,
   output logic              violation
);

   // Elaboration-time parameter checks
   if (WIN_LEN < 1) begin : g_bad_len
      $error("ccp_unit: WIN_LEN must be at least 1");
   end
   if (DATA_W < FN_NUM) begin : g_bad_width
      $error("ccp_unit: DATA_W too narrow for the status bits");
   end
   if (KEY_PROT == KEY_SPM) begin : g_bad_keys
      $error("ccp_unit: the two keys must differ");
   end

   key_class_e        kclass;
   logic [FN_NUM-1:0] win_load;
   logic [FN_NUM-1:0] win_use;
   logic [FN_NUM-1:0] win_act;
   logic              win_kill;
   logic              viol_now;

   ccp_key_decode #(
      .DATA_W   (DATA_W),
      .KEY_PROT (KEY_PROT),
      .KEY_SPM  (KEY_SPM)
   ) u_dec (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .kclass  (kclass)
   );

   assign win_kill          = (kclass == KC_BAD);
   assign win_load[FN_PROT] = (kclass == KC_PROT);
   assign win_load[FN_SPM]  = (kclass == KC_SPM);
   assign win_use[FN_PROT]  = prot_wr;
   assign win_use[FN_SPM]   = flash_hi_wr;

   for (genvar g = 0; g < FN_NUM; g++) begin : g_win
      ccp_window #(
         .WIN_LEN (WIN_LEN)
      ) u_win (
         .clk     (clk),
         .rst_n   (rst_n),
         .kill    (win_kill),
         .load    (win_load[g]),
         .consume (win_use[g]),
         .tick    (retire),
         .active  (win_act[g])
      );
   end

   assign prot_allow = win_act[FN_PROT];
   assign spm_armed  = win_act[FN_SPM];
   assign prog_start = flash_hi_wr & win_act[FN_SPM];
   assign irq_hold   = |win_act;

   always_comb begin
      rd_data             = '0;
      rd_data[FN_NUM-1:0] = win_act;
   end

   assign viol_now = (prot_wr & ~win_act[FN_PROT]) |
                     (flash_hi_wr & ~win_act[FN_SPM]);

   if (REG_VIOL) begin : g_viol_reg
      logic viol_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            viol_q <= 1'b0;
         else
            viol_q <= viol_now;
      end
      assign violation = viol_q;
   end else begin : g_viol_comb
      assign violation = viol_now;
   end

endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk #(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] KEY_PROT = 8'hD8,
   parameter logic [DATA_W-1:0] KEY_SPM  = 8'hE7,
   parameter bit                REG_VIOL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              prot_wr,
   input logic              flash_hi_wr,
   input logic              prot_allow,
   input logic              spm_armed,
   input logic              prog_start,
   input logic              irq_hold,
   input logic              violation
);

   a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == KEY_PROT) |=> (prot_allow && rd_data[0]));

   a_r3_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == KEY_SPM) |=> (spm_armed && rd_data[1]));

   a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:2] == '0);

   a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hold == (rd_data[0] || rd_data[1]));

   a_r6_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data != KEY_PROT && wr_data != KEY_SPM)
      |=> (!prot_allow && !spm_armed));

   a_r7_prot_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr && prot_allow && !wr_en) |=> !prot_allow);

   a_r8_spm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_hi_wr && spm_armed && !wr_en) |=> !spm_armed);

   a_r8_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (spm_armed && flash_hi_wr));

   if (REG_VIOL) begin : g_viol_props
      a_r9_viol_raised: assert property (@(posedge clk) disable iff (!rst_n)
         ((prot_wr && !prot_allow) || (flash_hi_wr && !spm_armed)) |=> violation);

      a_r9_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
         violation |-> $past((prot_wr && !prot_allow) || (flash_hi_wr && !spm_armed)));
   end

endmodule

bind ccp_unit ccp_unit_chk #(
   .DATA_W   (DATA_W),
   .KEY_PROT (KEY_PROT),
   .KEY_SPM  (KEY_SPM),
   .REG_VIOL (REG_VIOL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .prot_wr     (prot_wr),
   .flash_hi_wr (flash_hi_wr),
   .prot_allow  (prot_allow),
   .spm_armed   (spm_armed),
   .prog_start  (prog_start),
   .irq_hold    (irq_hold),
   .violation   (violation)
);

// File: tb/tb_ccp_unit.sv
`timescale 1ns/1ps
module tb_ccp_unit;

   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       retire = 1'b0;
   logic       prot_wr = 1'b0;
   logic       flash_hi_wr = 1'b0;
   logic       prot_allow, spm_armed, prog_start, irq_hold, violation;

   int checks = 0;
   int errors = 0;

   // Reference model state
   int pc = 0;
   int sc = 0;
   bit vq = 1'b0;

   always #4 clk = ~clk;

   ccp_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .retire(retire), .prot_wr(prot_wr),
      .flash_hi_wr(flash_hi_wr), .prot_allow(prot_allow),
      .spm_armed(spm_armed), .prog_start(prog_start),
      .irq_hold(irq_hold), .violation(violation)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int upd(input int c, input bit own_key, input bit bad_key,
                              input bit used, input bit r);
      if (bad_key) return 0;
      if (own_key) return N;
      if (used) return 0;
      if (r && c > 0) return c - 1;
      return c;
   endfunction

   task automatic step(input string tag, input bit w, input logic [7:0] d,
                       input bit r, input bit pw, input bit fw);
      bit bad;
      @(negedge clk);
      wr_en = w; wr_data = d; retire = r; prot_wr = pw; flash_hi_wr = fw;
      #1;
      chk(tag, "rd_data", rd_data, {6'b0, sc > 0, pc > 0});
      chk(tag, "prot_allow", prot_allow, pc > 0);
      chk(tag, "spm_armed", spm_armed, sc > 0);
      chk(tag, "irq_hold", irq_hold, (pc > 0) || (sc > 0));
      chk(tag, "prog_start", prog_start, fw && sc > 0);
      chk(tag, "violation", violation, vq);
      @(posedge clk);
      bad = w && d != 8'hD8 && d != 8'hE7;
      vq  = (pw && pc == 0) || (fw && sc == 0);
      pc  = upd(pc, w && d == 8'hD8, bad, pw, r);
      sc  = upd(sc, w && d == 8'hE7, bad, fw, r);
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 0, 8'h00, 0, 0, 0);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      #20;
      chk("R1", "rd_data", rd_data, 0);
      chk("R1", "outputs", {prot_allow, spm_armed, irq_hold, prog_start, violation}, 0);
      @(negedge clk); rst_n = 1'b1;
      idle("R1", 2);

      // R2, R4, R5: protected window counts retires only, sparse strobes
      step("R2", 1, 8'hD8, 1, 0, 0);
      for (int i = 0; i < N; i++) begin
         step("R2", 0, 8'h00, 0, 0, 0);
         step("R4", 0, 8'h00, 1, 0, 0);
      end
      idle("R5", 2);

      // R3: self-programming window expires, then a late flash write (R9)
      step("R3", 1, 8'hE7, 0, 0, 0);
      for (int i = 0; i < N; i++) step("R3", 0, 8'h00, 1, 0, 0);
      step("R9", 0, 8'h00, 0, 0, 1);
      idle("R9", 2);

      // R8: flash write inside the window starts programming
      step("R8", 1, 8'hE7, 0, 0, 0);
      step("R8", 0, 8'h00, 1, 0, 0);
      step("R8", 0, 8'h00, 0, 0, 1);
      idle("R8", 2);

      // R7: protected write consumes the window
      step("R7", 1, 8'hD8, 0, 0, 0);
      step("R7", 0, 8'h00, 0, 1, 0);
      step("R7", 0, 8'h00, 0, 1, 0);
      idle("R9", 2);

      // R9: both strobes outside any window, then one single
      step("R9", 0, 8'h00, 0, 1, 1);
      step("R9", 0, 8'h00, 0, 0, 0);
      step("R9", 0, 8'h00, 1, 1, 0);
      idle("R9", 2);

      // R6: bad key closes one and two open windows
      step("R6", 1, 8'hD8, 0, 0, 0);
      step("R6", 1, 8'h55, 0, 0, 0);
      step("R6", 1, 8'hE7, 0, 0, 0);
      step("R6", 1, 8'hD8, 0, 0, 0);
      step("R6", 1, 8'h00, 0, 0, 0);
      step("R6", 1, 8'hD9, 0, 0, 0);
      idle("R6", 2);

      // R10: reload of one window leaves the other counting
      step("R10", 1, 8'hD8, 0, 0, 0);
      step("R10", 0, 8'h00, 1, 0, 0);
      step("R10", 0, 8'h00, 1, 0, 0);
      step("R10", 1, 8'hE7, 1, 0, 0);
      step("R10", 0, 8'h00, 1, 0, 0);
      step("R10", 1, 8'hD8, 1, 0, 0);
      for (int i = 0; i < N + 1; i++) step("R10", 0, 8'h00, 1, 0, 0);
      idle("R10", 2);

      // R11: key write wins over same-cycle consume and retire
      step("R11", 1, 8'hD8, 1, 1, 0);
      step("R11", 1, 8'hD8, 1, 1, 0);
      step("R11", 0, 8'h00, 1, 0, 0);
      step("R11", 1, 8'hE7, 1, 0, 1);
      step("R11", 1, 8'h12, 1, 1, 1);
      step("R11", 0, 8'h00, 0, 0, 0);
      idle("R11", 2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule